// File: doc/BRIEF.md
# Three-Phase Three-Level Angle Pattern Generator

This block drives the three legs of a three-level converter with a fixed, low-rate switching pattern defined by switching angles rather than by a carrier. A 16-bit phase accumulator advances by a programmable step on every clock and stands for the output angle of phase a. Phases b and c follow the same pattern, lagging by one third and two thirds of a cycle. For each phase the block folds the instantaneous angle into the first quarter wave. It counts how many of the five programmed angles have been passed, and from that count and the half-cycle sign it picks one of three levels: positive half-link, neutral, or negative half-link.

A host precomputes five angles per quarter cycle so that the fundamental amplitude is set and chosen low-order harmonics are removed. It loads them through a small write port into a shadow set. A commit write checks the shadow set. A valid set goes live at the next wrap of the accumulator, which is the zero crossing of phase a, so a change of pattern never cuts a half cycle short. A set that is not strictly ascending, or that reaches a quarter cycle, is refused and the live set stays in use. Every level change is marked by a one-cycle strobe on that phase.

Top module: `trilevel_angle_pwm`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows every level as 2'b00 and every strobe low. Reset clears the accumulator and the step to 0. It loads both the live set and the shadow set with angles equal to one quarter cycle (0x4000), so the outputs stay neutral until a set is committed.
- R2: A write to address 5 loads the step. From the following clock, the accumulator adds the step on every edge, modulo 2^16. With step 0 the levels do not change.
- R3: For a phase angle θ whose top two bits are 00, let n be the number of live angles that are ≤ θ. The level is 2'b01 (positive) when n is odd and 2'b00 (neutral) when n is even.
- R4: In the second quarter of each half (bit 14 of θ set), the 15-bit position h = θ[14:0] is mirrored to q = 0x7FFF − h before counting.
- R5: When bit 15 of θ is set, the level is 2'b11 (negative) in place of 2'b01, with the same count rule applied to θ[14:0].
- R6: Phase a uses θ = acc. Phase b uses θ = acc − 0x5555 and phase c uses θ = acc − 0xAAAA, both modulo 2^16. Levels are packed in `lvl_o` with phase p in bits [2p+1:2p].
- R7: The level output is registered and reflects the accumulator value held during the previous cycle.
- R8: `edge_o[p]` is high for exactly the cycles in which the level of phase p differs from its value one cycle earlier.
- R9: Writes to addresses 0..4 change only the shadow angles α1..α5. The live pattern is unchanged until a commit and a later wrap.
- R10: A write to address 6 arms a swap if the shadow set is valid. The live set takes the shadow values on the first later edge at which the accumulator wraps (the sum carries out of 16 bits). A new shadow write cancels an armed swap.
- R11: A shadow set with any angle ≥ 0x4000, or any αk+1 ≤ αk, is refused at commit. The live set is kept and any armed swap is cancelled.
- R12: The level code 2'b10 never appears on any phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 3 | 0..4 shadow angles, 5 step, 6 commit |
| wr_data | input | 16 | Write data (angle or step as a fraction of 2^16) |
| lvl_o | output | 6 | Level code per phase, phase p in bits [2p+1:2p] |
| edge_o | output | 3 | One-cycle strobe per phase on a level change |

## Verification
The bench targets the fold at 90 degrees and the sign flip at 180 degrees. A wrong mirror would shift every second-quarter edge and change the edge count per period away from 20 (or from 18 for a set whose first angle is zero). It loads a set into the shadow without committing it. A design that let shadow writes reach the live set would show the new edge count at once. It commits a descending set and a set that reaches a quarter cycle; accepting either would change the pattern after the next wrap. Large steps make the accumulator jump straight from positive to negative and wrap often. This exposes a strobe that is tied to single transitions, or a swap that is not tied to the carry.

// File: rtl/tlp_pkg.sv
package tlp_pkg;

  typedef enum logic [1:0] {
    LVL_ZERO = 2'b00,
    LVL_POS  = 2'b01,
    LVL_NEG  = 2'b11
  } lvl_e;

endpackage

// File: rtl/tlp_phase_acc.sv
module tlp_phase_acc #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_we,
  input  logic [W-1:0] step_data,
  output logic [W-1:0] acc_o,
  output logic         wrap_o
);

  logic [W-1:0] acc_q;
  logic [W-1:0] step_q;
  logic [W-1:0] sum;

  // carry out of the add marks the zero crossing of phase a
  assign {wrap_o, sum} = {1'b0, acc_q} + {1'b0, step_q};
  assign acc_o = acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      step_q <= '0;
    end else begin
      acc_q <= sum;
      if (step_we) step_q <= step_data;
    end
  end

endmodule

// File: rtl/tlp_angle_bank.sv
module tlp_angle_bank #(
  parameter int ANG_W  = 16,
  parameter int N_ANG  = 5,
  parameter int ADDR_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   shadow_we,
  input  logic [ADDR_W-1:0]      shadow_idx,
  input  logic [ANG_W-1:0]       shadow_data,
  input  logic                   commit,
  input  logic                   wrap,
  output logic [N_ANG*ANG_W-1:0] active_o
);

  localparam logic [ANG_W-1:0] QUARTER = ANG_W'(1) << (ANG_W - 2);

  logic [ANG_W-1:0] shadow_q [N_ANG];
  logic [ANG_W-1:0] active_q [N_ANG];
  logic             pend_q;
  logic [N_ANG-1:0] ang_ok;
  logic             set_valid;
  logic             swap;

  // each angle below a quarter and above its predecessor
  for (genvar k = 0; k < N_ANG; k++) begin : g_chk
    if (k == 0) begin : g_first
      assign ang_ok[k] = shadow_q[k] < QUARTER;
    end else begin : g_rest
      assign ang_ok[k] = (shadow_q[k] < QUARTER) && (shadow_q[k-1] < shadow_q[k]);
    end
    assign active_o[k*ANG_W +: ANG_W] = active_q[k];
  end

  assign set_valid = &ang_ok;
  assign swap      = wrap && pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_ANG; k++) begin
        shadow_q[k] <= QUARTER;
        active_q[k] <= QUARTER;
      end
      pend_q <= 1'b0;
    end else begin
      if (swap) begin
        for (int k = 0; k < N_ANG; k++) active_q[k] <= shadow_q[k];
      end
      for (int k = 0; k < N_ANG; k++) begin
        if (shadow_we && shadow_idx == ADDR_W'(k)) shadow_q[k] <= shadow_data;
      end
      if (shadow_we)   pend_q <= 1'b0;
      else if (commit) pend_q <= set_valid;
      else if (swap)   pend_q <= 1'b0;
    end
  end

endmodule

// File: rtl/tlp_leg_slicer.sv
module tlp_leg_slicer
  import tlp_pkg::*;
#(
  parameter int               ANG_W  = 16,
  parameter int               N_ANG  = 5,
  parameter logic [ANG_W-1:0] OFFSET = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ANG_W-1:0]       acc,
  input  logic [N_ANG*ANG_W-1:0] active_flat,
  output logic [1:0]             lvl_o,
  output logic                   edge_o
);

  logic [ANG_W-1:0] theta;
  logic             neg_half;
  logic [ANG_W-2:0] half_pos;
  logic [ANG_W-2:0] fold;
  logic             odd;
  lvl_e             lvl_n;
  logic [1:0]       lvl_q;
  logic             edge_q;

  assign theta    = acc - OFFSET;
  assign neg_half = theta[ANG_W-1];
  assign half_pos = theta[ANG_W-2:0];
  // second quarter mirrors about 90 degrees: fold = all-ones minus position
  assign fold     = half_pos[ANG_W-2] ? ~half_pos : half_pos;

  always_comb begin
    odd = 1'b0;
    for (int k = 0; k < N_ANG; k++) begin
      odd = odd ^ (active_flat[k*ANG_W +: ANG_W] <= {1'b0, fold});
    end
    if (!odd)          lvl_n = LVL_ZERO;
    else if (neg_half) lvl_n = LVL_NEG;
    else               lvl_n = LVL_POS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= 2'b00;
      edge_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_n;
      edge_q <= (lvl_n != lvl_q);
    end
  end

  assign lvl_o  = lvl_q;
  assign edge_o = edge_q;

endmodule

// File: rtl/trilevel_angle_pwm.sv
module trilevel_angle_pwm #(
  parameter int ANG_W  = 16,
  parameter int N_ANG  = 5,
  parameter int N_PH   = 3,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ANG_W-1:0]  wr_data,
  output logic [2*N_PH-1:0] lvl_o,
  output logic [N_PH-1:0]   edge_o
);

  localparam logic [ADDR_W-1:0] ADDR_STEP   = ADDR_W'(N_ANG);
  localparam logic [ADDR_W-1:0] ADDR_COMMIT = ADDR_W'(N_ANG + 1);

  logic                   shadow_we;
  logic                   step_we;
  logic                   commit;
  logic [ANG_W-1:0]       acc;
  logic                   acc_wrap;
  logic [N_ANG*ANG_W-1:0] active_set;

  assign shadow_we = wr_en && (wr_addr < ADDR_STEP);
  assign step_we   = wr_en && (wr_addr == ADDR_STEP);
  assign commit    = wr_en && (wr_addr == ADDR_COMMIT);

  tlp_phase_acc #(.W(ANG_W)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .step_we   (step_we),
    .step_data (wr_data),
    .acc_o     (acc),
    .wrap_o    (acc_wrap)
  );

  tlp_angle_bank #(.ANG_W(ANG_W), .N_ANG(N_ANG), .ADDR_W(ADDR_W)) u_bank (
    .clk         (clk),
    .rst         (rst),
    .shadow_we   (shadow_we),
    .shadow_idx  (wr_addr),
    .shadow_data (wr_data),
    .commit      (commit),
    .wrap        (acc_wrap),
    .active_o    (active_set)
  );

  for (genvar p = 0; p < N_PH; p++) begin : g_leg
    localparam logic [ANG_W-1:0] OFS = ANG_W'((longint'(p) << ANG_W) / N_PH);
    tlp_leg_slicer #(.ANG_W(ANG_W), .N_ANG(N_ANG), .OFFSET(OFS)) u_leg (
      .clk         (clk),
      .rst         (rst),
      .acc         (acc),
      .active_flat (active_set),
      .lvl_o       (lvl_o[2*p +: 2]),
      .edge_o      (edge_o[p])
    );
  end

endmodule

// File: rtl/tlp_checker.sv
module tlp_checker #(
  parameter int ANG_W = 16,
  parameter int N_ANG = 5,
  parameter int N_PH  = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic [2*N_PH-1:0]      lvl_flat,
  input logic [N_PH-1:0]        edge_flat,
  input logic                   wrap,
  input logic [N_ANG*ANG_W-1:0] active
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (lvl_flat == '0 && edge_flat == '0));

  // R10
  set_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(active));

  for (genvar p = 0; p < N_PH; p++) begin : g_ph
    // R12
    legal_code_chk: assert property (@(posedge clk) disable iff (rst)
      lvl_flat[2*p +: 2] != 2'b10);

    // R8
    edge_match_chk: assert property (@(posedge clk) disable iff (rst)
      edge_flat[p] == (lvl_flat[2*p +: 2] != $past(lvl_flat[2*p +: 2])));
  end

endmodule

bind trilevel_angle_pwm tlp_checker #(.ANG_W(ANG_W), .N_ANG(N_ANG), .N_PH(N_PH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lvl_flat  (lvl_o),
  .edge_flat (edge_o),
  .wrap      (acc_wrap),
  .active    (active_set)
);

// File: tb/trilevel_angle_pwm_bench.sv
`timescale 1ns/1ps
module trilevel_angle_pwm_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [5:0] lvl_o;
  logic [2:0] edge_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  bit cmp_on = 0;
  bit seen_bad_code = 0;

  // reference state
  int m_acc, m_step, m_pend;
  int m_act[5];
  int m_sh[5];
  int m_lvl[3];
  int m_edge[3];

  always #10 clk = ~clk;

  trilevel_angle_pwm u_trilevel_angle_pwm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .lvl_o(lvl_o), .edge_o(edge_o)
  );

  function automatic int ref_level(int theta, int a0, int a1, int a2, int a3, int a4);
    int th, q, n;
    th = theta % 32768;
    q  = (th >= 16384) ? 32767 - th : th;
    n  = (a0 <= q) + (a1 <= q) + (a2 <= q) + (a3 <= q) + (a4 <= q);
    if (n % 2 == 0) return 0;
    return (theta >= 32768) ? 3 : 1;
  endfunction

  function automatic bit ref_valid();
    for (int k = 0; k < 5; k++) begin
      if (m_sh[k] >= 16384) return 0;
      if (k > 0 && m_sh[k] <= m_sh[k-1]) return 0;
    end
    return 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_acc = 0; m_step = 0; m_pend = 0;
      for (int k = 0; k < 5; k++) begin m_act[k] = 16384; m_sh[k] = 16384; end
      for (int p = 0; p < 3; p++) begin m_lvl[p] = 0; m_edge[p] = 0; end
    end else begin
      int sum;
      for (int p = 0; p < 3; p++) begin
        int th, nl;
        th = (m_acc - (p * 65536) / 3 + 65536) % 65536;
        nl = ref_level(th, m_act[0], m_act[1], m_act[2], m_act[3], m_act[4]);
        m_edge[p] = (nl != m_lvl[p]);
        m_lvl[p]  = nl;
      end
      sum = m_acc + m_step;
      if (sum > 65535 && m_pend != 0) begin
        for (int k = 0; k < 5; k++) m_act[k] = m_sh[k];
        m_pend = 0;
      end
      if (wr_en) begin
        if (wr_addr < 5) begin m_sh[wr_addr] = wr_data; m_pend = 0; end
        else if (wr_addr == 5) m_step = wr_data;
        else if (wr_addr == 6) m_pend = ref_valid();
      end
      m_acc = sum % 65536;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the reference (R3 R4 R5 R6 R7 R8)
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      int exp_l, exp_e;
      exp_l = m_lvl[0] | (m_lvl[1] << 2) | (m_lvl[2] << 4);
      exp_e = m_edge[0] | (m_edge[1] << 1) | (m_edge[2] << 2);
      check(lvl_o == exp_l[5:0], "R3 R4 R5 R6 R7 level", lvl_o, exp_l);
      check(edge_o == exp_e[2:0], "R8 strobe", edge_o, exp_e);
      for (int p = 0; p < 3; p++)
        if (lvl_o[2*p +: 2] == 2'b10) seen_bad_code = 1;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_set(int a0, int a1, int a2, int a3, int a4);
    wr(0, a0); wr(1, a1); wr(2, a2); wr(3, a3); wr(4, a4);
  endtask

  task automatic count_edges(int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      @(negedge clk);
      if (edge_o[0]) cnt++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int cnt;
    logic [5:0] held;
    repeat (5) @(negedge clk);
    // R1: outputs quiet during and just after reset
    check(lvl_o == 6'b0, "R1 reset level", lvl_o, 0);
    check(edge_o == 3'b0, "R1 reset strobe", edge_o, 0);
    rst = 1'b0;
    cmp_on = 1;

    // R2: step 0 holds every level
    repeat (20) @(negedge clk);
    check(lvl_o == 6'b0, "R1 idle neutral", lvl_o, 0);

    // set A live, period 1024 cycles
    load_set(16'h0400, 16'h0C00, 16'h1400, 16'h2000, 16'h3000);
    wr(6, 0);
    wr(5, 64);
    repeat (1200) @(negedge clk);
    count_edges(1024, cnt);
    check(cnt == 20, "R10 R4 set A edges per period", cnt, 20);

    // R9: shadow write of set D without commit leaves the pattern alone
    load_set(16'h0000, 16'h0800, 16'h1000, 16'h2000, 16'h3000);
    repeat (1100) @(negedge clk);
    count_edges(1024, cnt);
    check(cnt == 20, "R9 uncommitted shadow", cnt, 20);

    // R10: commit set D, pattern changes after the wrap
    wr(6, 0);
    repeat (1100) @(negedge clk);
    count_edges(1024, cnt);
    check(cnt == 18, "R10 set D edges per period", cnt, 18);

    // R11: descending set refused
    load_set(16'h0400, 16'h0300, 16'h1400, 16'h2000, 16'h3000);
    wr(6, 0);
    repeat (1100) @(negedge clk);
    count_edges(1024, cnt);
    check(cnt == 18, "R11 descending set refused", cnt, 18);

    // R11: set reaching a quarter refused
    load_set(16'h0400, 16'h0C00, 16'h1400, 16'h2000, 16'h4000);
    wr(6, 0);
    repeat (1100) @(negedge clk);
    count_edges(1024, cnt);
    check(cnt == 18, "R11 quarter-reaching set refused", cnt, 18);

    // odd step, new set committed mid-run (reference comparison)
    wr(5, 100);
    load_set(16'h0800, 16'h1000, 16'h1800, 16'h2800, 16'h3800);
    wr(6, 0);
    repeat (3000) @(negedge clk);

    // large steps: direct sign jumps and frequent wraps
    wr(5, 16'h3000);
    repeat (300) @(negedge clk);
    wr(5, 16'h7FF1);
    load_set(16'h0100, 16'h0900, 16'h1100, 16'h2200, 16'h3F00);
    wr(6, 0);
    repeat (300) @(negedge clk);

    // R2: step 0 freezes all phases
    wr(5, 0);
    repeat (3) @(negedge clk);
    held = lvl_o;
    repeat (64) @(negedge clk);
    check(lvl_o == held, "R2 step zero holds", lvl_o, held);
    check(edge_o == 3'b0, "R2 step zero no strobe", edge_o, 0);

    // R1: reset again mid-run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    check(lvl_o == 6'b0, "R1 reset after run", lvl_o, 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);

    // R12
    check(!seen_bad_code, "R12 code 10 never seen", seen_bad_code, 0);
    finish_run();
  end

endmodule